// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. The RAM is 16 bits wide, has two byte lanes and an 18-bit word address. The host issues one word request at a time through a valid/ready handshake. A request carries an address, a write flag, write data and a per-lane enable. The block then drives the RAM's active-low strobes: chip enable, output enable, the read/write line and one select per byte lane. Each phase lasts a whole number of clock cycles.

Every analogue timing figure is a parameter given in nanoseconds. A clock-period parameter turns each figure into a cycle count, rounded up. Read data is taken from the bus only after the longest access time has elapsed. It comes back with a one-cycle completion pulse. During a write the block keeps output enable high. It also waits for the RAM to release the shared bus before turning on its own driver, so the two never drive the bus together. The bus is modelled as separate in, out and drive-enable signals.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is active and after it is released, the block is idle. `req_ready` is 1. `mem_ce_n`, `mem_oe_n` and `mem_rw_n` are 1. Both bits of `mem_bsel_n` are 1. `dq_oe` and `rsp_done` are 0.
- R2: A read holds `mem_ce_n` and `mem_oe_n` at 0 and `mem_rw_n` at 1 for RD_CYC consecutive cycles. In the next cycle `rsp_done` is 1 and `rsp_data` holds the bus value sampled at the end of the last of those cycles.
- R3: Bit 0 of `req_be` and `mem_bsel_n` belongs to data bits 7:0. Bit 1 belongs to bits 15:8. `mem_bsel_n` is the inverse of the request's enables while chip enable is low. A disabled lane reads back as zero and is left unchanged in the RAM by a write.
- R4: `mem_addr`, `mem_bsel_n` and `dq_out` do not change while `mem_rw_n` is 0, or in the cycle in which it returns to 1.
- R5: `mem_oe_n` stays 1 throughout a write. `dq_oe` is never 1 while `mem_oe_n` is 0.
- R6: `dq_oe` rises only after `mem_rw_n` has been 0 for TA_CYC full cycles. After that it stays 1 until the cycle in which `mem_rw_n` returns to 1.
- R7: `mem_rw_n` stays low for WR_CYC cycles. WR_CYC is the largest of three values: the write-pulse count, the chip-enable-to-end count, and TA_CYC plus the data-setup count.
- R8: `req_ready` is 1 only when no access is in progress. Between any two accesses there is at least one cycle with `mem_ce_n` at 1.
- R9: Each count is the nanosecond figure divided by CLK_NS, rounded up. With defaults (10 ns clock; 70 ns access, 35 ns output-enable, 50 ns pulse, 60 ns enable-to-end, 30 ns setup, 30 ns release), RD_CYC=7, WR_CYC=6 and TA_CYC=3.
- R10: `rsp_done` is a single-cycle pulse and is 0 while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0 |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Read complete pulse |
| rsp_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rw_n | output | 1 | High read, low write |
| mem_bsel_n | output | 2 | Lane selects, active low, bit 0 = lower byte |
| dq_in | input | 16 | Data bus as seen by the block |
| dq_out | output | 16 | Data the block drives |
| dq_oe | output | 1 | Enables the block's bus driver |

## Verification
Two events can fall in the same cycle: a read's completion pulse and the acceptance of the next request, since `req_ready` is already high while `rsp_done` is shown. The bench presents each new request at the sample where it sees the previous completion, so reads and writes run back to back. It then checks that the result is intact and that chip enable is high for that cycle. It also checks that the next access starts exactly one cycle later with correct strobe counts and lane contents.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_WEND = 2'd3
  } asram_st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_step_ctr.sv
module asram_step_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/asram_lane_cap.sv
module asram_lane_cap #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic [LANES-1:0] lane_en,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             done
);
  localparam int LW = DW / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout[l*LW +: LW] <= '0;
      else if (sample) dout[l*LW +: LW] <= lane_en[l] ? din[l*LW +: LW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= sample;
  end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asram_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CLK_NS   = 10,
  parameter int T_ACC_NS = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_WP_NS  = 50,
  parameter int T_CW_NS  = 60,
  parameter int T_DS_NS  = 30,
  parameter int T_TA_NS  = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW/8-1:0] req_be,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ce_n,
  output logic            mem_oe_n,
  output logic            mem_rw_n,
  output logic [DW/8-1:0] mem_bsel_n,
  input  logic [DW-1:0]   dq_in,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe
);
  localparam int LANES  = DW / 8;
  localparam int RD_CYC = imax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
  localparam int TA_CYC = ns2cyc(T_TA_NS, CLK_NS);
  localparam int WR_CYC = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS)),
                               TA_CYC + ns2cyc(T_DS_NS, CLK_NS));
  localparam int CNT_W  = $clog2(imax(RD_CYC, WR_CYC) + 1);

  asram_st_e            st;
  logic [CNT_W-1:0]     cnt;
  logic [AW-1:0]        addr_q;
  logic [LANES-1:0]     be_q;
  logic [DW-1:0]        wd_q;

  // named events, also observed by the checker
  logic accept_ev, rd_sample_ev, wr_close_ev;

  assign req_ready    = (st == ST_IDLE);
  assign accept_ev    = req_valid && req_ready;
  assign rd_sample_ev = (st == ST_RD) && (cnt == CNT_W'(RD_CYC - 1));
  assign wr_close_ev  = (st == ST_WR) && (cnt == CNT_W'(WR_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept_ev) begin
          st     <= req_we ? ST_WR : ST_RD;
          addr_q <= req_addr;
          be_q   <= req_be;
          wd_q   <= req_wdata;
        end
        ST_RD:   if (rd_sample_ev) st <= ST_IDLE;
        ST_WR:   if (wr_close_ev)  st <= ST_WEND;
        ST_WEND: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  asram_step_ctr #(.W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((st == ST_IDLE) || (st == ST_WEND) || rd_sample_ev || wr_close_ev),
    .en    ((st == ST_RD) || (st == ST_WR)),
    .cnt   (cnt)
  );

  asram_lane_cap #(.DW(DW), .LANES(LANES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (rd_sample_ev),
    .lane_en (be_q),
    .din     (dq_in),
    .dout    (rsp_data),
    .done    (rsp_done)
  );

  // strobes decoded from registered state only
  assign mem_ce_n   = (st == ST_IDLE);
  assign mem_oe_n   = (st != ST_RD);
  assign mem_rw_n   = (st != ST_WR);
  assign mem_bsel_n = mem_ce_n ? {LANES{1'b1}} : ~be_q;
  assign mem_addr   = addr_q;
  assign dq_out     = wd_q;
  assign dq_oe      = ((st == ST_WR) && (cnt >= CNT_W'(TA_CYC))) || (st == ST_WEND);

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int AW     = 18,
  parameter int DW     = 16,
  parameter int LANES  = 2,
  parameter int TA_CYC = 3,
  parameter int WR_CYC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             done,
  input logic             ce_n,
  input logic             oe_n,
  input logic             rw_n,
  input logic             dq_oe,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    dout,
  input logic [LANES-1:0] bsel_n,
  input logic             rd_ev,
  input logic             wr_ev
);
  // cycles rw_n has spent low in the current pulse
  logic [7:0] lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lo_cnt <= '0;
    else if (rw_n)       lo_cnt <= '0;
    else if (lo_cnt != 8'hff) lo_cnt <= lo_cnt + 8'd1;
  end

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |-> rw_n);

  a_r2_sample_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> done);

  a_r4_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |=> ($stable(addr) && $stable(dout) && $stable(bsel_n)));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !rw_n) |-> (int'(lo_cnt) >= TA_CYC));

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rw_n) |-> (int'(lo_cnt) >= WR_CYC));

  a_r7_close_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (rw_n && !ce_n && dq_oe));

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ce_n);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind async_sram_ctrl asram_chk #(
  .AW(AW), .DW(DW), .LANES(LANES), .TA_CYC(TA_CYC), .WR_CYC(WR_CYC)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ready  (req_ready),
  .done   (rsp_done),
  .ce_n   (mem_ce_n),
  .oe_n   (mem_oe_n),
  .rw_n   (mem_rw_n),
  .dq_oe  (dq_oe),
  .addr   (mem_addr),
  .dout   (dq_out),
  .bsel_n (mem_bsel_n),
  .rd_ev  (rd_sample_ev),
  .wr_ev  (wr_close_ev)
);

// File: tb/async_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module async_sram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_RD = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_TA = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_WR = ((60 + CLK_PERIOD - 1) / CLK_PERIOD > EXP_TA + (30 + CLK_PERIOD - 1) / CLK_PERIOD)
                          ? (60 + CLK_PERIOD - 1) / CLK_PERIOD
                          : EXP_TA + (30 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_rw_n, dq_oe;
  logic [15:0] rsp_data, dq_out;
  wire  [15:0] dq_in;
  logic [17:0] mem_addr;
  logic [1:0]  mem_bsel_n;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_sram_ctrl #(.CLK_NS(CLK_PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_rw_n(mem_rw_n),
    .mem_bsel_n(mem_bsel_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // RAM model: 256 words indexed by the low address byte
  logic [15:0] ram [0:255];
  wire rd_on = !mem_ce_n && !mem_oe_n && mem_rw_n;
  assign dq_in[7:0]  = (rd_on && !mem_bsel_n[0]) ? ram[mem_addr[7:0]][7:0]  : 8'hzz;
  assign dq_in[15:8] = (rd_on && !mem_bsel_n[1]) ? ram[mem_addr[7:0]][15:8] : 8'hzz;

  always @(posedge mem_rw_n) begin
    if (!mem_ce_n && dq_oe) begin
      if (!mem_bsel_n[0]) ram[mem_addr[7:0]][7:0]  <= dq_out[7:0];
      if (!mem_bsel_n[1]) ram[mem_addr[7:0]][15:8] <= dq_out[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [17:0] a, input logic [1:0] be,
                       input logic [15:0] wd, input logic [15:0] exp);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (we) begin
      int lo = 0;
      int first = -1;
      bit bad_oe = 0, bad_stab = 0, bad_rdy = 0;
      while (!mem_rw_n && lo < 100) begin
        if (dq_oe && first < 0) first = lo;
        if (!mem_oe_n) bad_oe = 1;
        if (mem_addr !== a || dq_out !== wd || mem_bsel_n !== ~be) bad_stab = 1;
        if (req_ready) bad_rdy = 1;
        lo++;
        @(negedge clk);
      end
      if (mem_addr !== a || dq_out !== wd || mem_bsel_n !== ~be) bad_stab = 1;
      chk(lo == EXP_WR, "R7 write pulse cycles", lo, EXP_WR);
      chk(lo == EXP_WR, "R9 write count rounding", lo, EXP_WR);
      chk(first == EXP_TA, "R6 driver turn-on cycle", first, EXP_TA);
      chk(!bad_oe && mem_oe_n, "R5 oe_n high during write", bad_oe, 0);
      chk(!bad_stab, "R4 fields stable through write", bad_stab, 0);
      chk(!bad_rdy, "R8 ready low while busy", bad_rdy, 0);
      chk(dq_oe && !mem_ce_n, "R6 driver held at write end", {dq_oe, mem_ce_n}, 2'b10);
      @(negedge clk);
      chk(mem_ce_n && req_ready, "R8 idle gap after write", {mem_ce_n, req_ready}, 2'b11);
    end else begin
      int n = 0;
      bit bad = 0;
      while (!rsp_done && n < 100) begin
        if (rd_on) n++;
        if (dq_oe || req_ready) bad = 1;
        @(negedge clk);
      end
      chk(n == EXP_RD, "R2 read strobe cycles", n, EXP_RD);
      chk(n == EXP_RD, "R9 read count rounding", n, EXP_RD);
      chk(!bad, "R10 no done or drive during read", bad, 0);
      chk(rsp_data == exp, "R3 read data per lane", rsp_data, exp);
      chk(mem_ce_n && req_ready, "R8 ce high in done cycle", {mem_ce_n, req_ready}, 2'b11);
    end
  endtask

  // {we, addr, be, wdata, expected read}
  localparam logic [52:0] VEC [0:9] = '{
    {1'b1, 18'h00012, 2'b11, 16'hA5A5, 16'h0000},
    {1'b0, 18'h00012, 2'b11, 16'h0000, 16'hA5A5},
    {1'b1, 18'h00012, 2'b01, 16'h1234, 16'h0000},
    {1'b0, 18'h00012, 2'b11, 16'h0000, 16'hA534},
    {1'b1, 18'h00012, 2'b10, 16'hBEEF, 16'h0000},
    {1'b0, 18'h00012, 2'b01, 16'h0000, 16'h0034},
    {1'b0, 18'h00012, 2'b10, 16'h0000, 16'hBE00},
    {1'b1, 18'h3FF05, 2'b11, 16'h5A5A, 16'h0000},
    {1'b0, 18'h3FF05, 2'b11, 16'h0000, 16'h5A5A},
    {1'b0, 18'h00012, 2'b11, 16'h0000, 16'hBE34}
  };

  task automatic idle_check(input string req);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_rw_n && mem_bsel_n == 2'b11 && !dq_oe && !rsp_done,
        req, {req_ready, mem_ce_n, mem_oe_n, mem_rw_n, mem_bsel_n, dq_oe, rsp_done}, 8'b11111100);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    repeat (3) @(negedge clk);
    idle_check("R1 outputs during reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 outputs after reset");

    for (int i = 0; i < 10; i++) begin
      do_op(VEC[i][52], VEC[i][51:34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0]);
    end

    // lane masked read of an untouched word stays zero
    do_op(1'b0, 18'h00040, 2'b01, 16'h0, 16'h0000);

    // reset in the middle of a write returns the block to idle
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 18'h00077; req_be = 2'b11; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_check("R1 reset mid write");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 idle after mid-write reset");
    do_op(1'b0, 18'h00012, 2'b11, 16'h0, 16'hBE34);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule